// File: doc/BRIEF.md
# Operand Address Sequencer

This block resolves the operand of one instruction for an 8-bit processor with a 16-bit address space. The mode arrives already decoded, as a 4-bit code, together with a start pulse. The block then issues single-byte memory reads. It returns one of the following, according to the mode: an operand value, a 16-bit effective address, or a signed branch displacement. It also returns the program counter after the operand bytes have been consumed, and a flag that asks for one extra execution cycle when indexing carries into another 256-byte page.

The program counter, both index registers and the accumulator are sampled on the start cycle. Reads go out on `rd_en`/`rd_addr`, and the returned byte must be on `rd_data` in the following cycle. At most one read is in flight at any time. A one-cycle `done` pulse marks the point from which the outputs are valid. The outputs then hold until the next accepted start.

Top module: `ea_sequencer`

## Requirements
- R1: Mode codes 13, 14 and 15 are invalid. Such a code finishes with `done` one cycle after start and `bad_mode` = 1, and issues no read. A valid mode always finishes with `bad_mode` = 0.
- R2: Mode 0 (accumulator) returns `value` = the sampled accumulator, with `done` one cycle after start, no read, and `pc_out` equal to `pc_in`.
- R3: Mode 5 (implied) issues no read and finishes one cycle after start. `value`, `ea`, `rel_off` and `page_cross` are all zero, and `pc_out` equals `pc_in`.
- R4: Mode 4 (immediate) reads once, at `pc_in`. It returns that byte as `value`, sets `pc_out` = `pc_in`+1, and raises `done` three cycles after start.
- R5: Mode 9 (relative) reads once, at `pc_in`. It presents the byte on `rel_off`, sets `pc_out` = `pc_in`+1, and finishes three cycles after start. `rel_off` is zero for every other mode.
- R6: Modes 10, 11 and 12 (zero page, zero page + X, zero page + Y) each read one byte at `pc_in`. They give `ea` = {8'h00, (byte + 0/X/Y) mod 256} and `pc_out` = `pc_in`+1. In mode 12, X has no effect.
- R7: Mode 1 (absolute) reads the low byte at `pc_in` and the high byte at `pc_in`+1. It gives `ea` = {high, low} and `pc_out` = `pc_in`+2, and finishes four cycles after start.
- R8: Modes 2 and 3 (absolute + X, absolute + Y) give `ea` = ({high, low} + index) mod 65536. `page_cross` is 1 exactly when bits 15:8 of `ea` differ from the high byte. Only modes 2, 3 and 8 ever raise `page_cross`.
- R9: Mode 7 (pre-indexed indirect) reads the operand byte b and forms p = (b + X) mod 256. It reads the low byte at {00,p} and the high byte at {00,(p+1) mod 256}, then gives `ea` = {high, low}. It finishes five cycles after start with `pc_out` = `pc_in`+1.
- R10: Mode 8 (post-indexed indirect) reads the operand byte p. It reads the low byte at {00,p} and the high byte at {00,(p+1) mod 256}, then gives `ea` = {high, low} + Y with the page-cross rule of R8. It finishes five cycles after start.
- R11: Mode 6 (indirect) reads a 16-bit pointer P from `pc_in` and `pc_in`+1. It then reads the low byte at P and the high byte at P+1, with the carry propagating into the high byte. It gives `ea` = {high, low} and `pc_out` = `pc_in`+2, and finishes six cycles after start.
- R12: A read issued with `rd_en` in one cycle is consumed from `rd_data` in the next cycle, and reads only occur while `busy`. `busy` is high from the cycle after an accepted start through the `done` cycle. A start while busy is ignored.
- R13: `done` lasts exactly one cycle. Results hold after `done` until the next accepted start. Result fields that a mode does not produce read zero. After reset, `done`, `busy`, `rd_en` and all results are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin resolving an operand (accepted only when idle) |
| mode | input | 4 | Addressing-mode code, sampled with start |
| pc_in | input | 16 | Program counter at the first operand byte |
| x_in | input | 8 | X index register |
| y_in | input | 8 | Y index register |
| acc_in | input | 8 | Accumulator |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | 16 | Memory read address |
| rd_data | input | 8 | Read data, valid the cycle after rd_en |
| done | output | 1 | One-cycle pulse: results valid |
| busy | output | 1 | Sequence in progress |
| value | output | 8 | Operand value (accumulator or immediate modes) |
| ea | output | 16 | Effective address |
| rel_off | output | 8 | Signed branch displacement (relative mode) |
| pc_out | output | 16 | Program counter after the operand bytes |
| page_cross | output | 1 | Indexing crossed a page: one extra cycle |
| bad_mode | output | 1 | Mode code was invalid |

## Verification
The assertions assume that `rst_n` is low before the first clock edge. They also assume that `mode` is only meaningful in a cycle where `start` is high while the block is idle. Reads are expected to return data with exactly one cycle of latency. The bench meets these assumptions as follows. It drives every input on the falling clock edge and holds `start` for one cycle. Its memory model registers a byte on each rising edge where `rd_en` is set. The only deliberate violation is a start pulse issued mid-sequence, which checks that such a pulse is dropped.

// File: rtl/ea_sequencer.sv
module ea_sequencer #(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic [AW-1:0] pc_in,
  input  logic [DW-1:0] x_in,
  input  logic [DW-1:0] y_in,
  input  logic [DW-1:0] acc_in,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          done,
  output logic          busy,
  output logic [DW-1:0] value,
  output logic [AW-1:0] ea,
  output logic [DW-1:0] rel_off,
  output logic [AW-1:0] pc_out,
  output logic          page_cross,
  output logic          bad_mode
);
  localparam logic [3:0] M_ACC = 4'd0, M_ABS = 4'd1, M_ABX = 4'd2, M_ABY = 4'd3,
                         M_IMM = 4'd4, M_IMP = 4'd5, M_IND = 4'd6, M_PRX = 4'd7,
                         M_PSY = 4'd8, M_REL = 4'd9, M_ZP  = 4'd10, M_ZPX = 4'd11,
                         M_ZPY = 4'd12;

  typedef enum logic [2:0] {S_IDLE, S_OP0, S_OP1, S_OP2, S_PLO, S_PHI, S_FIN} st_t;

  st_t           st;
  logic [3:0]    md;
  logic [AW-1:0] pc_q, ptr_q, ea_q;
  logic [DW-1:0] x_q, y_q, lo_q, val_q, off_q;
  logic          cross_q, err_q;

  wire two_byte = (md == M_ABS) || (md == M_ABX) || (md == M_ABY) || (md == M_IND);
  wire zp_ptr   = (md == M_PRX) || (md == M_PSY);

  wire [DW-1:0] zp_off = (md == M_PRX || md == M_ZPX) ? x_q :
                         (md == M_ZPY) ? y_q : '0;
  wire [DW-1:0] zp_sum = rd_data + zp_off;

  wire [DW-1:0] ix16    = (md == M_ABY || md == M_PSY) ? y_q : x_q;
  wire [AW-1:0] word_in = {rd_data, lo_q};
  wire [AW-1:0] idx_sum = word_in + {{DW{1'b0}}, ix16};
  wire          crossed = idx_sum[AW-1:DW] != rd_data;

  wire [AW-1:0] ptr_next = (md == M_IND) ? ptr_q + AW'(1)
                                         : {{DW{1'b0}}, ptr_q[DW-1:0] + DW'(1)};

  always_comb begin
    rd_en   = 1'b0;
    rd_addr = '0;
    case (st)
      S_OP0: begin
        rd_en   = 1'b1;
        rd_addr = pc_q;
      end
      S_OP1: begin
        if (two_byte) begin
          rd_en   = 1'b1;
          rd_addr = pc_q;
        end else if (zp_ptr) begin
          rd_en   = 1'b1;
          rd_addr = {{DW{1'b0}}, zp_sum};
        end
      end
      S_OP2: begin
        if (md == M_IND) begin
          rd_en   = 1'b1;
          rd_addr = word_in;
        end
      end
      S_PLO: begin
        rd_en   = 1'b1;
        rd_addr = ptr_next;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      md      <= M_ACC;
      pc_q    <= '0;
      ptr_q   <= '0;
      ea_q    <= '0;
      x_q     <= '0;
      y_q     <= '0;
      lo_q    <= '0;
      val_q   <= '0;
      off_q   <= '0;
      cross_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          md      <= mode;
          pc_q    <= pc_in;
          x_q     <= x_in;
          y_q     <= y_in;
          ea_q    <= '0;
          val_q   <= '0;
          off_q   <= '0;
          cross_q <= 1'b0;
          err_q   <= 1'b0;
          if (mode > M_ZPY) begin
            err_q <= 1'b1;
            st    <= S_FIN;
          end else if (mode == M_ACC) begin
            val_q <= acc_in;
            st    <= S_FIN;
          end else if (mode == M_IMP) begin
            st <= S_FIN;
          end else begin
            st <= S_OP0;
          end
        end
        S_OP0: begin
          pc_q <= pc_q + AW'(1);
          st   <= S_OP1;
        end
        S_OP1: begin
          lo_q <= rd_data;
          if (two_byte) begin
            pc_q <= pc_q + AW'(1);
            st   <= S_OP2;
          end else if (zp_ptr) begin
            ptr_q <= {{DW{1'b0}}, zp_sum};
            st    <= S_PLO;
          end else begin
            case (md)
              M_IMM:   val_q <= rd_data;
              M_REL:   off_q <= rd_data;
              default: ea_q  <= {{DW{1'b0}}, zp_sum};
            endcase
            st <= S_FIN;
          end
        end
        S_OP2: begin
          if (md == M_IND) begin
            ptr_q <= word_in;
            st    <= S_PLO;
          end else begin
            if (md == M_ABS) begin
              ea_q <= word_in;
            end else begin
              ea_q    <= idx_sum;
              cross_q <= crossed;
            end
            st <= S_FIN;
          end
        end
        S_PLO: begin
          lo_q <= rd_data;
          st   <= S_PHI;
        end
        S_PHI: begin
          if (md == M_PSY) begin
            ea_q    <= idx_sum;
            cross_q <= crossed;
          end else begin
            ea_q <= word_in;
          end
          st <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign done       = (st == S_FIN);
  assign busy       = (st != S_IDLE);
  assign value      = val_q;
  assign ea         = ea_q;
  assign rel_off    = off_q;
  assign pc_out     = pc_q;
  assign page_cross = cross_q;
  assign bad_mode   = err_q;
endmodule

module ea_sequencer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [3:0]  mode,
  input logic        rd_en,
  input logic        done,
  input logic        busy,
  input logic [7:0]  value,
  input logic [15:0] ea,
  input logic [7:0]  rel_off,
  input logic        page_cross,
  input logic        bad_mode
);
  logic [3:0] md_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) md_seen <= 4'd0;
    else if (start && !busy) md_seen <= mode;
  end

  // R13
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12
  read_in_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> busy);

  // R1
  invalid_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode > 4'd12) |=> (done && bad_mode && !rd_en));

  // R3
  implied_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode == 4'd5) |=> (done && !rd_en && ea == 16'h0 && value == 8'h0));

  // R6
  page_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (md_seen == 4'd10 || md_seen == 4'd11 || md_seen == 4'd12)) |-> ea[15:8] == 8'h00);

  // R8
  cross_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && page_cross) |-> (md_seen == 4'd2 || md_seen == 4'd3 || md_seen == 4'd8));

  // R5
  offset_rel_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && md_seen != 4'd9) |-> rel_off == 8'h00);
endmodule

bind ea_sequencer ea_sequencer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .rd_en(rd_en),
  .done(done), .busy(busy), .value(value), .ea(ea), .rel_off(rel_off),
  .page_cross(page_cross), .bad_mode(bad_mode)
);

// File: tb/ea_sequencer_test.sv
`timescale 1ns/1ps
module ea_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = 4'd0;
  logic [15:0] pc_in = '0;
  logic [7:0]  x_in = '0, y_in = '0, acc_in = '0;
  logic        rd_en;
  logic [15:0] rd_addr;
  logic [7:0]  rd_data = '0;
  logic        done, busy, page_cross, bad_mode;
  logic [7:0]  value, rel_off;
  logic [15:0] ea, pc_out;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  ea_sequencer uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .pc_in(pc_in),
    .x_in(x_in), .y_in(y_in), .acc_in(acc_in), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .done(done), .busy(busy), .value(value), .ea(ea),
    .rel_off(rel_off), .pc_out(pc_out), .page_cross(page_cross), .bad_mode(bad_mode)
  );

  logic [15:0] ov_a [16];
  logic [7:0]  ov_d [16];
  logic        ov_v [16];
  logic [15:0] rd_log [16];
  int          rd_cnt = 0;

  function automatic logic [7:0] mem_at(input logic [15:0] a);
    logic [7:0] d;
    d = a[7:0] ^ a[15:8] ^ 8'h3C;
    for (int i = 0; i < 16; i++)
      if (ov_v[i] && ov_a[i] == a) d = ov_d[i];
    return d;
  endfunction

  always @(posedge clk) begin
    if (rd_en) begin
      rd_data <= mem_at(rd_addr);
      rd_log[rd_cnt % 16] <= rd_addr;
      rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic clear_mem();
    for (int i = 0; i < 16; i++) ov_v[i] = 1'b0;
  endtask

  task automatic poke(input logic [15:0] a, input logic [7:0] d);
    for (int i = 0; i < 16; i++) begin
      if (!ov_v[i]) begin
        ov_a[i] = a; ov_d[i] = d; ov_v[i] = 1'b1;
        return;
      end
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] m, input logic [15:0] pc,
                        input logic [7:0] x, input logic [7:0] y, input logic [7:0] a,
                        output int lat, output int nrd, output int base);
    @(negedge clk);
    mode = m; pc_in = pc; x_in = x; y_in = y; acc_in = a; start = 1'b1;
    base = rd_cnt;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    nrd = rd_cnt - base;
  endtask

  function automatic logic [15:0] logged(input int idx);
    return rd_log[idx % 16];
  endfunction

  task automatic t_reset();
    chk("R13 reset done", done, 0);
    chk("R13 reset busy", busy, 0);
    chk("R13 reset rd_en", rd_en, 0);
    chk("R13 reset ea", ea, 0);
    chk("R13 reset bad_mode", bad_mode, 0);
  endtask

  task automatic t_acc();
    int lat, n, b;
    run_op(4'd0, 16'h1234, 8'h01, 8'h02, 8'h9E, lat, n, b);
    chk("R2 acc latency", lat, 1);
    chk("R2 acc value", value, 8'h9E);
    chk("R2 acc reads", n, 0);
    chk("R2 acc pc", pc_out, 16'h1234);
  endtask

  task automatic t_imp();
    int lat, n, b;
    run_op(4'd5, 16'h4321, 8'h01, 8'h02, 8'h77, lat, n, b);
    chk("R3 imp latency", lat, 1);
    chk("R3 imp reads", n, 0);
    chk("R3 imp value", value, 0);
    chk("R3 imp ea", ea, 0);
    chk("R3 imp rel", rel_off, 0);
    chk("R3 imp pc", pc_out, 16'h4321);
  endtask

  task automatic t_bad();
    int lat, n, b;
    run_op(4'd14, 16'h0100, 8'h00, 8'h00, 8'h00, lat, n, b);
    chk("R1 bad latency", lat, 1);
    chk("R1 bad flag", bad_mode, 1);
    chk("R1 bad reads", n, 0);
    run_op(4'd13, 16'h0100, 8'h00, 8'h00, 8'h00, lat, n, b);
    chk("R1 bad13 flag", bad_mode, 1);
    run_op(4'd0, 16'h0100, 8'h00, 8'h00, 8'h11, lat, n, b);
    chk("R1 good clears flag", bad_mode, 0);
  endtask

  task automatic t_imm();
    int lat, n, b;
    clear_mem();
    poke(16'h0400, 8'h77);
    run_op(4'd4, 16'h0400, 8'h00, 8'h00, 8'h00, lat, n, b);
    chk("R4 imm latency", lat, 3);
    chk("R4 imm value", value, 8'h77);
    chk("R4 imm pc", pc_out, 16'h0401);
    chk("R4 imm reads", n, 1);
    chk("R4 imm addr", logged(b), 16'h0400);
  endtask

  task automatic t_rel();
    int lat, n, b;
    clear_mem();
    poke(16'h2000, 8'hF0);
    run_op(4'd9, 16'h2000, 8'h00, 8'h00, 8'h00, lat, n, b);
    chk("R5 rel latency", lat, 3);
    chk("R5 rel offset", rel_off, 8'hF0);
    chk("R5 rel pc", pc_out, 16'h2001);
    chk("R13 rel unused ea", ea, 0);
    chk("R13 rel unused value", value, 0);
  endtask

  task automatic t_zp();
    int lat, n, b;
    clear_mem();
    poke(16'h3000, 8'h42);
    poke(16'h3100, 8'h20);
    poke(16'h3200, 8'h80);
    run_op(4'd10, 16'h3000, 8'h33, 8'h44, 8'h00, lat, n, b);
    chk("R6 zp ea", ea, 16'h0042);
    chk("R6 zp pc", pc_out, 16'h3001);
    run_op(4'd11, 16'h3100, 8'hF0, 8'h00, 8'h00, lat, n, b);
    chk("R6 zpx wrap ea", ea, 16'h0010);
    run_op(4'd12, 16'h3200, 8'h11, 8'h05, 8'h00, lat, n, b);
    chk("R6 zpy ea", ea, 16'h0085);
    chk("R6 zpy reads", n, 1);
  endtask

  task automatic t_abs();
    int lat, n, b;
    clear_mem();
    poke(16'h10FF, 8'h34);
    poke(16'h1100, 8'h12);
    run_op(4'd1, 16'h10FF, 8'h00, 8'h00, 8'h00, lat, n, b);
    chk("R7 abs latency", lat, 4);
    chk("R7 abs ea", ea, 16'h1234);
    chk("R7 abs pc", pc_out, 16'h1101);
    chk("R7 abs reads", n, 2);
    chk("R7 abs addr lo", logged(b), 16'h10FF);
    chk("R7 abs addr hi", logged(b + 1), 16'h1100);
    repeat (3) @(negedge clk);
    chk("R13 hold done low", done, 0);
    chk("R13 hold ea", ea, 16'h1234);
  endtask

  task automatic t_absidx();
    int lat, n, b;
    clear_mem();
    poke(16'h5000, 8'hF0); poke(16'h5001, 8'h12);
    poke(16'h5100, 8'h00); poke(16'h5101, 8'h12);
    poke(16'h5200, 8'hF0); poke(16'h5201, 8'hFF);
    run_op(4'd2, 16'h5000, 8'h20, 8'h00, 8'h00, lat, n, b);
    chk("R8 absx ea", ea, 16'h1310);
    chk("R8 absx cross", page_cross, 1);
    run_op(4'd3, 16'h5100, 8'hFF, 8'h10, 8'h00, lat, n, b);
    chk("R8 absy ea", ea, 16'h1210);
    chk("R8 absy no cross", page_cross, 0);
    run_op(4'd2, 16'h5200, 8'h20, 8'h00, 8'h00, lat, n, b);
    chk("R8 absx wrap ea", ea, 16'h0010);
    chk("R8 absx wrap cross", page_cross, 1);
  endtask

  task automatic t_prex();
    int lat, n, b;
    clear_mem();
    poke(16'h6000, 8'hF8);
    poke(16'h00FF, 8'hCD);
    poke(16'h0000, 8'hAB);
    run_op(4'd7, 16'h6000, 8'h07, 8'h00, 8'h00, lat, n, b);
    chk("R9 prex latency", lat, 5);
    chk("R9 prex ea", ea, 16'hABCD);
    chk("R9 prex pc", pc_out, 16'h6001);
    chk("R9 prex ptr lo", logged(b + 1), 16'h00FF);
    chk("R9 prex ptr hi wrap", logged(b + 2), 16'h0000);
    chk("R9 prex cross", page_cross, 0);
  endtask

  task automatic t_posty();
    int lat, n, b;
    clear_mem();
    poke(16'h7000, 8'hFF);
    poke(16'h00FF, 8'hF0);
    poke(16'h0000, 8'h20);
    poke(16'h7100, 8'h40);
    poke(16'h0040, 8'h00);
    poke(16'h0041, 8'h30);
    run_op(4'd8, 16'h7000, 8'h00, 8'h25, 8'h00, lat, n, b);
    chk("R10 posty latency", lat, 5);
    chk("R10 posty ea", ea, 16'h2115);
    chk("R10 posty cross", page_cross, 1);
    chk("R10 posty hi wrap", logged(b + 2), 16'h0000);
    run_op(4'd8, 16'h7100, 8'h99, 8'h10, 8'h00, lat, n, b);
    chk("R10 posty ea2", ea, 16'h3010);
    chk("R10 posty no cross", page_cross, 0);
  endtask

  task automatic t_ind();
    int lat, n, b;
    clear_mem();
    poke(16'h8000, 8'hFF);
    poke(16'h8001, 8'h21);
    poke(16'h21FF, 8'h78);
    poke(16'h2200, 8'h56);
    run_op(4'd6, 16'h8000, 8'h00, 8'h00, 8'h00, lat, n, b);
    chk("R11 ind latency", lat, 6);
    chk("R11 ind ea", ea, 16'h5678);
    chk("R11 ind pc", pc_out, 16'h8002);
    chk("R11 ind reads", n, 4);
    chk("R11 ind ptr lo", logged(b + 2), 16'h21FF);
    chk("R11 ind ptr hi carry", logged(b + 3), 16'h2200);
  endtask

  task automatic t_busy();
    int lat;
    clear_mem();
    poke(16'h9000, 8'h34);
    poke(16'h9001, 8'h12);
    @(negedge clk);
    mode = 4'd1; pc_in = 16'h9000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R12 busy after start", busy, 1);
    mode = 4'd0; acc_in = 8'h55; pc_in = 16'hAAAA; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 2;
    while (!done && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    chk("R12 ignored start latency", lat, 4);
    chk("R12 ignored start ea", ea, 16'h1234);
    chk("R12 ignored start value", value, 0);
    chk("R12 ignored start pc", pc_out, 16'h9002);
    @(negedge clk);
    chk("R12 idle after done", busy, 0);
  endtask

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_acc();
    t_imp();
    t_bad();
    t_imm();
    t_rel();
    t_zp();
    t_abs();
    t_absidx();
    t_prex();
    t_posty();
    t_ind();
    t_busy();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule